// File: doc/BRIEF.md
# Indexed Peripheral Clock-Enable Generator

This block keeps a small bank of clock settings, one entry per peripheral number, behind a single 32-bit control register. Software first writes a peripheral number to pick an entry, then reads the register to see that entry's settings. A write with the command bit set stores a new source choice, divide ratio and enable bit into the entry it names. That write also picks the entry for later reads.

Each entry drives its own pulse generator. The generator watches the tick input of its chosen source and gives a one-cycle clock-enable pulse once every (divider + 1) ticks. It stops while the entry is disabled. Source codes have a gap: code 3 names no source.

Top module: `perclk_gen_bank`

## Requirements
- R1: After a synchronous active-low reset, the selected number is 0, and every entry holds enable 0, divider 0 and source code 0. A read returns 0, and no `clk_en` bit pulses even while every source ticks.
- R2: A write with bit 12 clear only changes the selected number (bits [6:0]). Stored entries stay the same, whatever the other bits of the word hold.
- R3: A write with bit 12 set and a number below `NUM_ENTRIES` stores the source code from bits [10:8], the divider from bits [27:20] and the enable from bit 29 into that entry. The same write also selects that number.
- R4: `rd_data` shows the selected number in [6:0], its source code in [10:8], its divider in [27:20] and its enable in bit 29. All other bits read 0.
- R5: While an entry is enabled, `clk_en[i]` is high for one cycle, in the cycle after the tick that completes each group of (divider + 1) source ticks. Divider 0 passes every tick through, and divider 255 gives one pulse per 256 ticks. Idle cycles between ticks do not count.
- R6: A command write that clears the enable stops the pulses and keeps the source and divider. Re-enabling starts a fresh count, so the first pulse comes after a full divider + 1 ticks.
- R7: Source codes 0, 1 and 2 select tick inputs 0, 1 and 2. Codes 4 and 5 select inputs 3 and 4. Codes 3, 6 and 7 select nothing, so no pulses appear.
- R8: A command write that changes an entry's divider or source code clears that entry's tick count. The first pulse after the change then comes after exactly (new divider + 1) ticks.
- R9: A command write with a number at or above `NUM_ENTRIES` changes no entry. Reading such a number returns the number with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 32 | Write word (number, command bit, fields) |
| rd_data | output | 32 | Settings of the selected entry |
| src_tick | input | NUM_SRC | One tick-enable per clock source |
| clk_en | output | NUM_ENTRIES | Generated clock-enable pulse per entry |

## Verification
The divider is tried with continuous ticks at ratios 0, 1, 2 and 255. It is also tried with idle gaps between ticks, which shows whether idle cycles are wrongly counted. Source selection is tried by ticking only the chosen input, and then every input except it. Each mapped code is tried, along with the hole and the codes past the end. This separates a correct code-to-input map from a contiguous one.

Register access is tried in three ways:
- A full sweep of writes and read-backs over every entry.
- A select word whose other field bits are all ones, which shows whether a select write is taken as a command.
- Writes to a number out of range.

Two sequences check the count being cleared. In one, an entry is disabled partway through a count. In the other, the divider is lowered below the current count. A design that does not clear the count shows either an early first pulse or a long stall.

// File: rtl/pcg_pkg.sv
// Package: register field positions and source-code map shared by the
// clock-enable generator bank. Assumes a 32-bit control word.
package pcg_pkg;

    localparam int REG_W    = 32;
    localparam int SEL_W    = 3;
    localparam int DIV_W    = 8;
    localparam int SEL_LSB  = 8;
    localparam int DIV_LSB  = 20;
    localparam int EN_BIT   = 29;
    localparam int CMD_BIT  = 12;
    localparam int HOLE_ENC = 3;   // source code that names no input

    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] div;
        logic [SEL_W-1:0] sel;
    } pcg_cfg_t;

    // Source code that selects tick input s (codes skip HOLE_ENC).
    function automatic int src_code(input int s);
        return (s < HOLE_ENC) ? s : s + 1;
    endfunction

endpackage

// File: rtl/pcg_regs.sv
// Register bank: holds the selected number and one settings entry per
// peripheral. A select write changes only the number; a command write stores
// fields into an entry in range. Assumes NUM_ENTRIES fits in ID_W bits.
module pcg_regs
    import pcg_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int ID_W        = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [REG_W-1:0]            wr_data,
    output logic [REG_W-1:0]            rd_data,
    output pcg_cfg_t [NUM_ENTRIES-1:0]  cfg,
    output logic [NUM_ENTRIES-1:0]      restart
);

    localparam logic [REG_W-1:0] RD_MASK =
        REG_W'((1 << ID_W) - 1) | (REG_W'((1 << SEL_W) - 1) << SEL_LSB) |
        (REG_W'((1 << DIV_W) - 1) << DIV_LSB) | (REG_W'(1) << EN_BIT);

    logic [ID_W-1:0] id_q;
    logic [ID_W-1:0] wid;
    logic            is_cmd;
    pcg_cfg_t        new_cfg;
    pcg_cfg_t [NUM_ENTRIES-1:0] cfg_q;
    logic            unused_wr;

    assign wid         = wr_data[ID_W-1:0];
    assign is_cmd      = wr_data[CMD_BIT];
    assign new_cfg.en  = wr_data[EN_BIT];
    assign new_cfg.div = wr_data[DIV_LSB +: DIV_W];
    assign new_cfg.sel = wr_data[SEL_LSB +: SEL_W];
    assign unused_wr   = ^wr_data;
    assign cfg         = cfg_q;

    // Selected-number register: every write picks the number it carries.
    always_ff @(posedge clk) begin
        if (!rst_n)     id_q <= '0;
        else if (wr_en) id_q <= wid;
    end

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        logic hit;
        assign hit = wr_en && is_cmd && (wid == ID_W'(i));
        assign restart[i] = hit && ((new_cfg.div != cfg_q[i].div) ||
                                    (new_cfg.sel != cfg_q[i].sel));

        // Entry storage: only a command write naming this entry updates it.
        always_ff @(posedge clk) begin
            if (!rst_n)   cfg_q[i] <= '0;
            else if (hit) cfg_q[i] <= new_cfg;
        end

        // R2 / R9: writes that do not name this entry as a command leave it alone
        a_r2_entry_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !(is_cmd && wid == ID_W'(i))) |=> $stable(cfg_q[i]));
    end

    // Read path: number always shown, fields only for an entry in range.
    always_comb begin
        rd_data = '0;
        rd_data[ID_W-1:0] = id_q;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (id_q == ID_W'(i)) begin
                rd_data[SEL_LSB +: SEL_W] = cfg_q[i].sel;
                rd_data[DIV_LSB +: DIV_W] = cfg_q[i].div;
                rd_data[EN_BIT]           = cfg_q[i].en;
            end
        end
    end

    // R3: a command write in range reads back as the masked word
    a_r3_cmd_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_cmd && (int'(wid) < NUM_ENTRIES)) |=>
        (rd_data == ($past(wr_data) & RD_MASK)));

    // R4: bits outside the field layout always read zero
    a_r4_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~RD_MASK) == '0);

    // R9: a number out of range reads back with no field bits
    a_r9_oor_read: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(id_q) >= NUM_ENTRIES) |-> (rd_data[REG_W-1:ID_W] == '0));

endmodule

// File: rtl/pcg_divider.sv
// Pulse generator for one entry: picks a source tick by code, counts ticks
// while enabled and emits a registered one-cycle pulse every div+1 ticks.
// Assumes src_tick inputs are synchronous to clk.
module pcg_divider
    import pcg_pkg::*;
#(
    parameter int NUM_SRC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  pcg_cfg_t           cfg,
    input  logic               restart,
    output logic               pulse
);

    logic             hit;
    logic [DIV_W-1:0] cnt;

    // Source mux: match the code against each input's code; holes match none.
    always_comb begin
        hit = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (src_code(s) < (1 << SEL_W) && cfg.sel == SEL_W'(src_code(s)))
                hit = src_tick[s];
        end
    end

    // Tick counter and pulse register; disable or restart clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !cfg.en) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else if (hit) begin
            if (cnt == cfg.div) begin
                cnt   <= '0;
                pulse <= 1'b1;
            end else begin
                cnt   <= cnt + DIV_W'(1);
                pulse <= 1'b0;
            end
        end else begin
            pulse <= 1'b0;
        end
    end

    // R6: a disabled entry produces no pulse on the following cycle
    a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |=> !pulse);

    // R5: divider 0 turns every selected tick into a pulse
    a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && cfg.div == '0 && hit && !restart) |=> pulse);

    // R5: the count never passes the divider of an enabled entry
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.en |-> (cnt <= cfg.div));

    // R8: a settings change clears the count
    a_r8_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0 && !pulse));

endmodule

// File: rtl/perclk_gen_bank.sv
// Top: control-register bank plus one pulse generator per peripheral entry.
// Assumes a single clock domain for the bus and all source ticks.
module perclk_gen_bank
    import pcg_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int NUM_SRC     = 5,
    parameter int ID_W        = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [31:0]            wr_data,
    output logic [31:0]            rd_data,
    input  logic [NUM_SRC-1:0]     src_tick,
    output logic [NUM_ENTRIES-1:0] clk_en
);

    pcg_cfg_t [NUM_ENTRIES-1:0] cfg;
    logic [NUM_ENTRIES-1:0]     restart;

    pcg_regs #(.NUM_ENTRIES(NUM_ENTRIES), .ID_W(ID_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cfg(cfg), .restart(restart)
    );

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_div
        pcg_divider #(.NUM_SRC(NUM_SRC)) u_div (
            .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
            .cfg(cfg[i]), .restart(restart[i]), .pulse(clk_en[i])
        );
    end

endmodule

// File: tb/sim_perclk_gen_bank.sv
// Bench: sweeps register access over all entries and measures pulse spacing.
module sim_perclk_gen_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NE = 4;
    localparam int NS = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [NS-1:0] src_tick = '0;
    logic [NE-1:0] clk_en;

    int checks = 0;
    int errors = 0;
    int e_sel [NE];
    int e_div [NE];
    int e_en  [NE];

    perclk_gen_bank #(.NUM_ENTRIES(NE), .NUM_SRC(NS), .ID_W(7)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .src_tick(src_tick), .clk_en(clk_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] cmd_w(int id, int sel, int dv, int en);
        return 32'(id) | (32'(1) << 12) | (32'(sel) << 8) | (32'(dv) << 20) | (32'(en) << 29);
    endfunction

    function automatic logic [31:0] exp_rd(int id);
        if (id >= NE) return 32'(id);
        return 32'(id) | (32'(e_sel[id]) << 8) | (32'(e_div[id]) << 20) | (32'(e_en[id]) << 29);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] w);
        @(negedge clk); wr_en = 1'b1; wr_data = w;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic cmd(input int id, input int sel, input int dv, input int en);
        wr(cmd_w(id, sel, dv, en));
        if (id < NE) begin e_sel[id] = sel; e_div[id] = dv; e_en[id] = en; end
    endtask

    task automatic rd_chk(input int id, input string req);
        wr(32'(id));
        chk(rd_data === exp_rd(id), req, rd_data, exp_rd(id));
    endtask

    // Drive n ticks on mask with gap idle cycles between; compare every cycle.
    task automatic run(input int e, input logic [NS-1:0] mask, input int d,
                       input int n, input int gap, input bit quiet, input string req);
        int bad = 0;
        logic fa = 1'b0, fe = 1'b0;
        for (int k = 1; k <= n; k++) begin
            logic act, exp;
            @(negedge clk); src_tick = mask;
            @(posedge clk); #1;
            act = clk_en[e];
            exp = quiet ? 1'b0 : ((k % (d + 1)) == 0);
            if (act !== exp) begin if (bad == 0) begin fa = act; fe = exp; end bad++; end
            src_tick = '0;
            for (int g = 0; g < gap; g++) begin
                @(posedge clk); #1;
                if (clk_en[e] !== 1'b0) begin if (bad == 0) begin fa = clk_en[e]; fe = 1'b0; end bad++; end
            end
        end
        chk(bad == 0, req, 32'(fa), 32'(fe));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NE; i++) begin e_sel[i] = 0; e_div[i] = 0; e_en[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset contents and silent outputs
        chk(rd_data === 32'h0, "R1 reset read", rd_data, 32'h0);
        for (int i = 0; i < NE; i++) rd_chk(i, "R1 entry reset");
        run(0, '1, 0, 6, 0, 1'b1, "R1 no pulse after reset");
        begin
            int seen = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk); src_tick = '1;
                @(posedge clk); #1; if (clk_en !== '0) seen++;
            end
            src_tick = '0;
            chk(seen == 0, "R1 all entries quiet", 32'(seen), 32'h0);
        end

        // R3 / R4: command sweep and read-back of every entry
        for (int i = 0; i < NE; i++) cmd(i, (i * 3 + 1) % 8, i * 37 + 1, i & 1);
        for (int i = 0; i < NE; i++) rd_chk(i, "R3 R4 readback");

        // R9: out-of-range command ignored, read shows number only
        wr(cmd_w(6, 5, 9, 1));
        chk(rd_data === 32'h6, "R9 oor read", rd_data, 32'h6);
        rd_chk(6, "R9 oor select");
        for (int i = 0; i < NE; i++) rd_chk(i, "R9 entries untouched");

        // R2: a select word with all field bits set stores nothing
        wr(32'h3FFF_EF01);
        chk(rd_data === exp_rd(1), "R2 select only", rd_data, exp_rd(1));
        rd_chk(2, "R2 other entry kept");

        // R5: ratios 0, 1, 2 (with gaps), 255
        cmd(0, 0, 0, 1);   run(0, '1, 0, 8, 0, 1'b0, "R5 div0");
        cmd(0, 0, 1, 1);   run(0, '1, 1, 10, 0, 1'b0, "R5 div1");
        cmd(0, 0, 2, 1);   run(0, '1, 2, 12, 2, 1'b0, "R5 div2 gaps");
        cmd(0, 0, 255, 1); run(0, '1, 255, 520, 0, 1'b0, "R5 div255");

        // R7: source code map with a hole
        cmd(1, 4, 0, 1); run(1, 5'b01000, 0, 6, 0, 1'b0, "R7 code4 to input3");
        run(1, 5'b10111, 0, 6, 0, 1'b1, "R7 code4 ignores others");
        cmd(1, 5, 0, 1); run(1, 5'b10000, 0, 6, 0, 1'b0, "R7 code5 to input4");
        cmd(1, 2, 0, 1); run(1, 5'b00100, 0, 6, 0, 1'b0, "R7 code2 to input2");
        cmd(1, 3, 0, 1); run(1, '1, 0, 6, 0, 1'b1, "R7 code3 hole");
        cmd(1, 7, 0, 1); run(1, '1, 0, 6, 0, 1'b1, "R7 code7 unmapped");

        // R6: disable mid-count, retention, fresh count on re-enable
        cmd(2, 1, 2, 1); run(2, 5'b00010, 2, 7, 0, 1'b0, "R6 before disable");
        cmd(2, 1, 2, 0); run(2, 5'b00010, 2, 9, 0, 1'b1, "R6 disabled quiet");
        rd_chk(2, "R6 settings retained");
        cmd(2, 1, 2, 1); run(2, 5'b00010, 2, 9, 0, 1'b0, "R6 re-enable full ratio");

        // R8: lowering the divider below the count restarts it
        cmd(3, 0, 3, 1); run(3, 5'b00001, 3, 2, 0, 1'b0, "R8 partial count");
        cmd(3, 0, 1, 1); run(3, 5'b00001, 1, 6, 0, 1'b0, "R8 new ratio after change");
        cmd(3, 2, 1, 1); run(3, 5'b00100, 1, 6, 0, 1'b0, "R8 source change");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule